// File: doc/BRIEF.md
# ADC Conversion Handshake Sequencer

This block runs the bus handshake of an external 8-bit analog-to-digital converter on behalf of the logic around it. A one-cycle start request launches a sequence. The sequencer selects the converter and drives its write strobe low for a programmed number of cycles. It then releases the strobe, and the converter begins converting on that rising edge. Next the sequencer polls the converter's active-low done flag through a synchronizer. When the flag falls, the sequencer selects the converter again and holds its read strobe low, which enables the converter's output drivers. The byte on the data pins is captured at the end of that read pulse.

The captured sample is presented with a one-cycle valid strobe. A busy flag covers the whole sequence, and start requests made while busy have no effect. If the done flag never falls, a wait limit ends the sequence with a one-cycle timeout flag and no read. All strobes to the converter are active low and registered.

Top module: `adc_handshake_seq`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, and busy, sample valid and timeout are low.
- R2: A start sampled high while idle drives the write strobe low from the next cycle for exactly WR_LOW cycles. Chip select is low for all of those cycles and for one further cycle after the write strobe returns high.
- R3: The done flag passes through a SYNC_STAGES-flop synchronizer and is ignored during the first SYNC_STAGES wait cycles. After that, the read strobe falls SYNC_STAGES+1 cycles after the done flag falls.
- R4: The read strobe stays low for exactly RD_LOW cycles with chip select low. Write and read strobes are never low together, and neither is low while chip select is high.
- R5: The data pins are captured in the last read-low cycle. sample_o then holds that byte, and sample_valid_o is high for one cycle, in the cycle after the read strobe returns high.
- R6: busy_o rises only in the cycle after an accepted start and stays high without a gap until the sequence ends. It is low in the cycle that carries sample_valid_o or timeout_o.
- R7: A start request made while busy is ignored. The sequence length is unchanged, and no new sequence follows it.
- R8: If the done flag is not seen low within TIMEOUT wait cycles, timeout_o pulses for one cycle and the block returns to idle. No read strobe is issued, and sample_o keeps its previous value.
- R9: Chip select is high throughout the wait for the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a sequence |
| intr_n_i | input | 1 | Converter done flag, active low, asynchronous |
| adc_data_i | input | DATA_W | Converter data pins |
| cs_n_o | output | 1 | Converter chip select, active low |
| wr_n_o | output | 1 | Start strobe, active low; rising edge starts conversion |
| rd_n_o | output | 1 | Read strobe / output enable, active low |
| busy_o | output | 1 | Sequence in progress |
| sample_o | output | DATA_W | Last captured sample |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample |
| timeout_o | output | 1 | One-cycle strobe marking an abandoned wait |

## Verification
The write strobe is due low in the first cycle after the start edge. The read strobe is due low SYNC_STAGES+1 cycles after the done flag falls, and valid is due in the cycle after the read strobe rises. A timeout is due after WR_LOW+1+TIMEOUT busy cycles. The bench drives inputs at falling edges and samples every output at the falling edge. It counts low widths and gaps cycle by cycle against those numbers and does not wait for events. A behavioural converter model raises its done flag when the write strobe falls and drops it a programmed number of cycles after the rising edge. A stuck setting keeps the flag high, which forces the timeout path.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_REL,
    ST_WAIT,
    ST_RD_LO
  } seq_state_e;
endpackage

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff <= RST_VAL;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/adc_hs_cnt.sv
module adc_hs_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)              q <= '0;
    else if (load)        q <= load_val;
    else if (q != '0)     q <= q - 1'b1;
  end

  assign zero = (q == '0);
endmodule

// File: rtl/adc_handshake_seq.sv
module adc_handshake_seq #(
  parameter int DATA_W      = 8,
  parameter int WR_LOW      = 4,
  parameter int RD_LOW      = 3,
  parameter int TIMEOUT     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              intr_n_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              cs_n_o,
  output logic              wr_n_o,
  output logic              rd_n_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic              timeout_o
);
  import adc_hs_pkg::*;

  localparam int PW_MAX = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int PW_W   = $clog2(PW_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam logic [PW_W-1:0] WR_LOAD = PW_W'(WR_LOW - 1);
  localparam logic [PW_W-1:0] RD_LOAD = PW_W'(RD_LOW - 1);
  localparam logic [TO_W-1:0] TO_LOAD = TO_W'(TIMEOUT - 1);
  localparam logic [TO_W-1:0] BLANK_LIM = TO_W'(TIMEOUT - 1 - SYNC_STAGES);

  seq_state_e state, nxt;
  logic intr_s;
  logic pw_load, pw_zero, wt_load, wt_zero;
  logic [PW_W-1:0] pw_val, pw_q;
  logic [TO_W-1:0] wt_q;
  logic cap, to_hit, blank_done;

  adc_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(intr_n_i), .q(intr_s)
  );

  adc_hs_cnt #(.W(PW_W)) u_pw (
    .clk(clk), .rst(rst), .load(pw_load), .load_val(pw_val),
    .q(pw_q), .zero(pw_zero)
  );

  adc_hs_cnt #(.W(TO_W)) u_wt (
    .clk(clk), .rst(rst), .load(wt_load), .load_val(TO_LOAD),
    .q(wt_q), .zero(wt_zero)
  );

  assign blank_done = (wt_q <= BLANK_LIM);

  always_comb begin
    nxt     = state;
    pw_load = 1'b0;
    pw_val  = '0;
    wt_load = 1'b0;
    cap     = 1'b0;
    to_hit  = 1'b0;
    unique case (state)
      ST_IDLE: if (start_i) begin
        nxt     = ST_WR_LO;
        pw_load = 1'b1;
        pw_val  = WR_LOAD;
      end
      ST_WR_LO: if (pw_zero) nxt = ST_WR_REL;
      ST_WR_REL: begin
        nxt     = ST_WAIT;
        wt_load = 1'b1;
      end
      ST_WAIT: begin
        if (blank_done && !intr_s) begin
          nxt     = ST_RD_LO;
          pw_load = 1'b1;
          pw_val  = RD_LOAD;
        end else if (wt_zero) begin
          nxt    = ST_IDLE;
          to_hit = 1'b1;
        end
      end
      ST_RD_LO: if (pw_zero) begin
        nxt = ST_IDLE;
        cap = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      cs_n_o         <= 1'b1;
      wr_n_o         <= 1'b1;
      rd_n_o         <= 1'b1;
      busy_o         <= 1'b0;
      sample_valid_o <= 1'b0;
      timeout_o      <= 1'b0;
      sample_o       <= '0;
    end else begin
      state          <= nxt;
      cs_n_o         <= !(nxt == ST_WR_LO || nxt == ST_WR_REL || nxt == ST_RD_LO);
      wr_n_o         <= (nxt != ST_WR_LO);
      rd_n_o         <= (nxt != ST_RD_LO);
      busy_o         <= (nxt != ST_IDLE);
      sample_valid_o <= cap;
      timeout_o      <= to_hit;
      if (cap) sample_o <= adc_data_i;
    end
  end

  // R4
  wr_sel_chk: assert property (@(posedge clk) disable iff (rst) !wr_n_o |-> !cs_n_o);
  // R4
  rd_sel_chk: assert property (@(posedge clk) disable iff (rst) !rd_n_o |-> !cs_n_o);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!wr_n_o && !rd_n_o));
  // R5
  valid_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> ($rose(rd_n_o) && !busy_o));
  // R6
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  // R8
  timeout_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!sample_valid_o && $stable(sample_o) && rd_n_o));
  // R9
  wait_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> cs_n_o);
endmodule

// File: tb/adc_handshake_seq_bench.sv
module adc_handshake_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int WRL = 4;
  localparam int RDL = 3;
  localparam int TO = 40;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic intr_n;
  logic [DW-1:0] adc_data;
  logic cs_n_o, wr_n_o, rd_n_o, busy_o, sample_valid_o, timeout_o;
  logic [DW-1:0] sample_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [DW-1:0] adc_val = '0;
  int conv_len = 5;
  bit stuck = 1'b0;
  logic wr_prev;
  int cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_handshake_seq #(.DATA_W(DW), .WR_LOW(WRL), .RD_LOW(RDL),
                      .TIMEOUT(TO), .SYNC_STAGES(SS)) u_adc_handshake_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .intr_n_i(intr_n),
    .adc_data_i(adc_data), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o),
    .busy_o(busy_o), .sample_o(sample_o), .sample_valid_o(sample_valid_o),
    .timeout_o(timeout_o)
  );

  // behavioural converter
  always @(posedge clk) begin
    if (rst) begin
      intr_n  <= 1'b0;
      cnt     <= 0;
      wr_prev <= 1'b1;
    end else begin
      wr_prev <= wr_n_o;
      if (!cs_n_o && wr_prev && !wr_n_o) intr_n <= 1'b1;
      if (!cs_n_o && !wr_prev && wr_n_o) begin
        intr_n <= 1'b1;
        cnt    <= conv_len;
      end else if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1 && !stuck) intr_n <= 1'b0;
      end
    end
  end
  assign adc_data = (!cs_n_o && !rd_n_o) ? adc_val : '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [DW-1:0] val, input int conv, input bit stk,
                         input bit poke, output int busy_len);
    int wr_len = 0, rd_len = 0, cyc = 0, intr_at = -1, rd_at = -1;
    bit cs_bad = 0, excl_bad = 0, wait_cs_bad = 0, rel_ok = 0;
    logic pw = 1'b1, pr = 1'b1, pi;
    logic [DW-1:0] old = sample_o;
    adc_val = val; conv_len = conv; stuck = stk;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    // R2: write strobe low in first cycle after start edge
    chk(wr_n_o == 1'b0, "R2 wr low latency", wr_n_o, 0);
    pi = intr_n;
    while (busy_o && cyc < 1000) begin
      if (poke && cyc == 3) start_i = 1'b1; else start_i = 1'b0;
      if (!wr_n_o) begin wr_len++; if (cs_n_o) cs_bad = 1; end
      if (!pw && wr_n_o) rel_ok = !cs_n_o;
      if (!rd_n_o) begin rd_len++; if (cs_n_o) cs_bad = 1; end
      if (!wr_n_o && !rd_n_o) excl_bad = 1;
      if (pr && !rd_n_o) rd_at = cyc;
      if (pi && !intr_n && intr_at < 0) intr_at = cyc;
      if (pw && pr && wr_n_o && rd_n_o && cs_n_o == 1'b0 && cyc > WRL + 1) wait_cs_bad = 1;
      if (cyc > WRL && rd_n_o && rd_at < 0 && !cs_n_o) wait_cs_bad = 1;
      pw = wr_n_o; pr = rd_n_o; pi = intr_n;
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    busy_len = cyc;
    chk(wr_len == WRL, "R2 wr low width", wr_len, WRL);
    chk(rel_ok, "R2 cs low at wr rise", rel_ok, 1);
    chk(!cs_bad && !excl_bad, "R4 strobe select rules", cs_bad + 2*excl_bad, 0);
    chk(!wait_cs_bad, "R9 cs high while waiting", wait_cs_bad, 0);
    if (!stk) begin
      chk(rd_at - intr_at == SS + 1, "R3 rd after intr", rd_at - intr_at, SS + 1);
      chk(rd_len == RDL, "R4 rd low width", rd_len, RDL);
      chk(sample_valid_o === 1'b1, "R5 valid after rd", sample_valid_o, 1);
      chk(sample_o === val, "R5 sample value", sample_o, val);
      chk(!timeout_o, "R6 busy low with valid, no timeout", timeout_o, 0);
    end else begin
      chk(busy_len == WRL + 1 + TO, "R8 timeout busy span", busy_len, WRL + 1 + TO);
      chk(timeout_o === 1'b1, "R8 timeout pulse", timeout_o, 1);
      chk(rd_len == 0 && !sample_valid_o, "R8 no read on timeout", rd_len, 0);
      chk(sample_o === old, "R8 sample kept", sample_o, old);
    end
    @(negedge clk);
    chk(!sample_valid_o && !timeout_o, "R5 R8 one-cycle strobes",
        sample_valid_o + timeout_o, 0);
  endtask

  task automatic t_reset();
    chk(cs_n_o && wr_n_o && rd_n_o, "R1 strobes high", {cs_n_o, wr_n_o, rd_n_o}, 7);
    chk(!busy_o && !sample_valid_o && !timeout_o, "R1 flags low",
        {busy_o, sample_valid_o, timeout_o}, 0);
  endtask

  task automatic t_ignore();
    int base_len, poke_len;
    run_seq(8'h3C, 8, 1'b0, 1'b0, base_len);
    run_seq(8'hC3, 8, 1'b0, 1'b1, poke_len);
    chk(poke_len == base_len, "R7 length unchanged", poke_len, base_len);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!busy_o && cs_n_o, "R7 no extra sequence", busy_o, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int bl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_seq(8'hA5, 5, 1'b0, 1'b0, bl);
    run_seq(8'h00, 1, 1'b0, 1'b0, bl);
    run_seq(8'hFF, 20, 1'b0, 1'b0, bl);
    t_ignore();
    run_seq(8'h77, 5, 1'b1, 1'b0, bl);
    run_seq(8'h5A, 3, 1'b0, 1'b0, bl);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule